// File: doc/BRIEF.md
# Streaming Row Dot-Product Unit

This unit computes one element of a matrix-vector product per weight row. Two 16-bit signed Q8.8 streams come in side by side: one carries input-vector elements and the other the elements of one weight-matrix row. The weight stream also carries a flag on the final element of each row. Each matched pair is multiplied into a 32-bit Q16.16 product and summed into a 32-bit accumulator. When the flagged pair has been added, the total is narrowed back to a saturated Q8.8 value and offered on a result stream. The accumulator then starts the next row from zero.

There is no bias port. The caller places the bias as the final element of each weight row and pairs it with a vector element of fixed-point one (0x0100), so the bias is added as an ordinary product. Rows padded with zero pairs to meet an alignment give the same result as the unpadded row. Row length is set only by where the last flag falls, so any length from one pair upward is accepted.

All three streams use valid/ready. A pair is taken on a clock edge only when both input valids are high and the result register is empty or being emptied in that same cycle. Each input's ready therefore depends on the other input's valid. A result held with `res_ready` low stops both inputs and keeps its value. Up to one pair is taken per clock.

Top module: `rowdot_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid`, `vec_ready` and `wgt_ready` are low when no input is valid.
- R2: `vec_ready` equals `wgt_valid` AND (NOT `res_valid` OR `res_ready`). `wgt_ready` equals `vec_valid` AND (NOT `res_valid` OR `res_ready`). A pair is taken only on an edge where both readies and both valids are high.
- R3: The result is the sum, modulo 2^32 in two's complement, of the signed 16x16 products of every pair in the row, narrowed as in R8 and R9.
- R4: `res_valid` rises in the cycle right after the edge that takes a pair with `wgt_last` set, and at no other time.
- R5: Each row starts from a zero sum; nothing from an earlier row carries into a later one.
- R6: A final pair of vector 0x0100 and weight b adds exactly b (Q8.8) to the row result; for example, vector {0x0100, 0x0200, 0x0100} with weights {0x0080, 0x0040, 0x0180} gives 0x0280.
- R7: Pairs whose vector and weight are both 0x0000 leave the result unchanged.
- R8: When the 32-bit sum lies within [-2^23, 2^23-1], the result is bits [23:8] of the sum (truncation toward minus infinity; for example, a sum of -1 gives 0xFFFF).
- R9: A sum above 2^23-1 gives 0x7FFF; a sum below -2^23 gives 0x8000.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change. No result is lost or repeated.
- R11: A row of a single pair (with `wgt_last` set on that pair) gives that pair's narrowed product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_valid | input | 1 | Vector element present |
| vec_ready | output | 1 | Vector element taken on this edge |
| vec_data | input | 16 | Vector element, signed Q8.8 |
| wgt_valid | input | 1 | Weight element present |
| wgt_ready | output | 1 | Weight element taken on this edge |
| wgt_data | input | 16 | Weight element, signed Q8.8 |
| wgt_last | input | 1 | Marks the final element of a row |
| res_valid | output | 1 | Row result present |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 16 | Row result, signed Q8.8, saturated |

## Verification
The readies are combinational, so they are compared within the same cycle in which the valids and `res_ready` are presented. A row result is due one edge after the edge that takes its flagged pair. The bench's cycle model pushes its expected result at that same edge and compares `res_valid` and `res_data` in the following low clock phase. Stalled results are checked on each held cycle for an unchanged value. Results from directed rows are collected at their handshake edge and compared against values worked out by hand.

// File: rtl/rowdot_pkg.sv
package rowdot_pkg;
  // Default geometry shared by the unit and its sub-blocks
  parameter int unsigned RD_DATA_W = 16;  // element width, signed
  parameter int unsigned RD_FRAC_W = 8;   // fractional bits of an element
  parameter int unsigned RD_ACC_W  = 32;  // accumulator width
endpackage

// File: rtl/rowdot_join.sv
// Joins the two element streams: a pair moves only when both sides are valid
// and the result slot can take a completed row.
module rowdot_join (
  input  logic a_valid,
  input  logic b_valid,
  input  logic slot_free,
  output logic a_ready,
  output logic b_ready,
  output logic fire
);
  always_comb begin
    a_ready = b_valid && slot_free;
    b_ready = a_valid && slot_free;
    fire    = a_valid && b_valid && slot_free;
  end
endmodule

// File: rtl/rowdot_mac.sv
// Signed multiply-accumulate that clears itself after the last element of a row.
module rowdot_mac #(
  parameter int unsigned DATA_W = rowdot_pkg::RD_DATA_W,
  parameter int unsigned ACC_W  = rowdot_pkg::RD_ACC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic                     last,
  input  logic signed [DATA_W-1:0] vec,
  input  logic signed [DATA_W-1:0] wgt,
  output logic signed [ACC_W-1:0]  total
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod = vec * wgt;

  generate
    if (ACC_W > PROD_W) begin : g_extend
      assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end else begin : g_fit
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  // Running total including the pair presented this cycle
  assign total = acc_q + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (fire) begin
      acc_q <= last ? '0 : total;
    end
  end

  // R5: a finished row leaves nothing behind for the next one
  p_row_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (acc_q == '0))
    else $error("accumulator not cleared after row end");
endmodule

// File: rtl/rowdot_narrow.sv
// Shifts the wide sum down by the fractional bits and saturates to the element range.
module rowdot_narrow #(
  parameter int unsigned DATA_W = rowdot_pkg::RD_DATA_W,
  parameter int unsigned FRAC_W = rowdot_pkg::RD_FRAC_W,
  parameter int unsigned ACC_W  = rowdot_pkg::RD_ACC_W
) (
  input  logic signed [ACC_W-1:0]  wide,
  output logic signed [DATA_W-1:0] narrow
);
  localparam int unsigned TOP_W = ACC_W - DATA_W + 1;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] shifted;
  logic [TOP_W-1:0]        top_bits;
  logic                    fits;

  assign shifted  = wide >>> FRAC_W;
  assign top_bits = shifted[ACC_W-1:DATA_W-1];
  assign fits     = (top_bits == '0) || (top_bits == '1);

  always_comb begin
    if (fits) begin
      narrow = shifted[DATA_W-1:0];
    end else if (wide[ACC_W-1]) begin
      narrow = NEG_MIN;
    end else begin
      narrow = POS_MAX;
    end
  end

  // R9: narrowing, saturated or not, never flips the sign of the sum
  always_comb begin
    p_sign_kept_r9: assert (narrow[DATA_W-1] == wide[ACC_W-1])
      else $error("narrowed sign differs from wide sign");
  end
endmodule

// File: rtl/rowdot_unit.sv
// Streaming row dot-product: one saturated Q-format result per weight row.
module rowdot_unit #(
  parameter int unsigned DATA_W = rowdot_pkg::RD_DATA_W,
  parameter int unsigned FRAC_W = rowdot_pkg::RD_FRAC_W,
  parameter int unsigned ACC_W  = rowdot_pkg::RD_ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_valid,
  output logic              vec_ready,
  input  logic [DATA_W-1:0] vec_data,
  input  logic              wgt_valid,
  output logic              wgt_ready,
  input  logic [DATA_W-1:0] wgt_data,
  input  logic              wgt_last,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);
  logic                     slot_free;
  logic                     fire;
  logic signed [ACC_W-1:0]  total;
  logic signed [DATA_W-1:0] row_val;

  // The result register may take a new row when empty or draining now
  assign slot_free = !res_valid || res_ready;

  rowdot_join u_join (
    .a_valid   (vec_valid),
    .b_valid   (wgt_valid),
    .slot_free (slot_free),
    .a_ready   (vec_ready),
    .b_ready   (wgt_ready),
    .fire      (fire)
  );

  rowdot_mac #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
  ) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .last  (wgt_last),
    .vec   ($signed(vec_data)),
    .wgt   ($signed(wgt_data)),
    .total (total)
  );

  rowdot_narrow #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W)
  ) u_narrow (
    .wide   (total),
    .narrow (row_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (fire && wgt_last) begin
      res_valid <= 1'b1;
      res_data  <= row_val;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R4: the cycle after a row's last pair is taken, its result is offered
  p_valid_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && wgt_last) |=> res_valid)
    else $error("result missing after row end");

  // R4: a result appears only because a row ended
  p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(wgt_valid && wgt_ready && wgt_last))
    else $error("result without row end");

  // R10: a stalled result holds its value
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)))
    else $error("stalled result changed");

  // R2: nothing is taken while the result slot is blocked
  p_block_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> (!vec_ready && !wgt_ready))
    else $error("input taken while result blocked");
endmodule

// File: tb/tb_rowdot_unit.sv
module tb_rowdot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_valid = 1'b0;
  logic        vec_ready;
  logic [15:0] vec_data = '0;
  logic        wgt_valid = 1'b0;
  logic        wgt_ready;
  logic [15:0] wgt_data = '0;
  logic        wgt_last = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stall_en = 0;
  bit hold = 0;
  logic [15:0] got[$];

  // model state
  logic               m_valid = 1'b0;
  logic [15:0]        m_data = '0;
  logic signed [31:0] m_acc = '0;

  always #5 clk = ~clk;

  rowdot_unit dut (
    .clk(clk), .rst_n(rst_n),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
    .wgt_valid(wgt_valid), .wgt_ready(wgt_ready), .wgt_data(wgt_data),
    .wgt_last(wgt_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [15:0] ref_narrow(logic signed [31:0] s);
    if (s > 32'sh007FFFFF) return 16'h7FFF;
    if (s < 32'shFF800000) return 16'h8000;
    return s[23:8];
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    if (hold) res_ready <= 1'b0;
    else if (stall_en) res_ready <= 1'($urandom % 2);
    else res_ready <= 1'b1;
  end

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0;
      m_acc   = '0;
    end else begin
      logic slot;
      logic signed [31:0] p;
      slot = !m_valid || res_ready;
      if (m_valid && res_ready) m_valid = 1'b0;
      if (vec_valid && wgt_valid && slot) begin
        p = $signed(vec_data) * $signed(wgt_data);
        if (wgt_last) begin
          m_data  = ref_narrow(m_acc + p);
          m_valid = 1'b1;
          m_acc   = '0;
        end else begin
          m_acc = m_acc + p;
        end
      end
    end
  end

  // per-cycle comparison in the low phase
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic free;
      free = !m_valid || res_ready;
      check("R4", "res_valid", {15'd0, res_valid}, {15'd0, m_valid});
      if (m_valid) check("R3", "res_data", res_data, m_data);
      check("R2", "vec_ready", {15'd0, vec_ready}, {15'd0, wgt_valid && free});
      check("R2", "wgt_ready", {15'd0, wgt_ready}, {15'd0, vec_valid && free});
      if (res_valid && res_ready) got.push_back(res_data);
    end
  end

  task automatic push_pair(logic [15:0] v, logic [15:0] w, logic l, int skew);
    @(negedge clk);
    vec_data = v; wgt_data = w; wgt_last = l;
    vec_valid = 1'b1;
    wgt_valid = (skew == 0);
    repeat (skew) @(negedge clk);
    wgt_valid = 1'b1;
    #1;
    while (!(vec_ready && wgt_ready)) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    vec_valid = 1'b0; wgt_valid = 1'b0; wgt_last = 1'b0;
  endtask

  task automatic expect_row(input logic [15:0] v[$], input logic [15:0] w[$],
                            logic [15:0] exp, string req);
    got.delete();
    for (int i = 0; i < v.size(); i++) push_pair(v[i], w[i], i == v.size() - 1, 0);
    drop();
    while (got.size() == 0) @(posedge clk);
    check(req, "row result", got[0], exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=complete");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    // R1: outputs low during reset
    check("R1", "res_valid in reset", {15'd0, res_valid}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check("R1", "res_valid after reset", {15'd0, res_valid}, 16'd0);
    check("R1", "vec_ready idle", {15'd0, vec_ready}, 16'd0);
    check("R1", "wgt_ready idle", {15'd0, wgt_ready}, 16'd0);

    // R6: bias folded as last column with unit vector element
    expect_row('{16'h0100, 16'h0200, 16'h0100}, '{16'h0080, 16'h0040, 16'h0180}, 16'h0280, "R6");
    // R5: identical row again gives identical result
    expect_row('{16'h0100, 16'h0200, 16'h0100}, '{16'h0080, 16'h0040, 16'h0180}, 16'h0280, "R5");
    // R7: zero padding changes nothing
    expect_row('{16'h0100, 16'h0000, 16'h0000, 16'h0100},
               '{16'h0300, 16'h0000, 16'h0000, 16'hFF00}, 16'h0200, "R7");
    // R8 / R11: single pair rows, truncation toward minus infinity
    expect_row('{16'h0080}, '{16'h0003}, 16'h0001, "R11");
    expect_row('{16'h0001}, '{16'hFFFF}, 16'hFFFF, "R8");
    expect_row('{16'h7F00}, '{16'h0100}, 16'h7F00, "R8");
    // R9: saturation both ways
    expect_row('{16'h7FFF}, '{16'h7FFF}, 16'h7FFF, "R9");
    expect_row('{16'h7FFF}, '{16'h8000}, 16'h8000, "R9");
    expect_row('{16'h7FFF, 16'h7FFF}, '{16'h7FFF, 16'h8001}, 16'h0000, "R3");

    // R10: stalled result holds while the next row waits
    got.delete();
    hold = 1;
    push_pair(16'h0100, 16'h0500, 1'b1, 0);
    @(negedge clk);
    vec_data = 16'h0100; wgt_data = 16'h0100; wgt_last = 1'b1;
    vec_valid = 1'b1; wgt_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #3;
      check("R10", "held valid", {15'd0, res_valid}, 16'd1);
      check("R10", "held data", res_data, 16'h0500);
      check("R2", "blocked ready", {15'd0, vec_ready}, 16'd0);
    end
    hold = 0;
    @(negedge clk);
    @(negedge clk);
    vec_valid = 1'b0; wgt_valid = 1'b0; wgt_last = 1'b0;
    while (got.size() < 2) @(posedge clk);
    check("R10", "first after stall", got[0], 16'h0500);
    check("R10", "second after stall", got[1], 16'h0100);
    check("R10", "no duplicate", 16'(got.size()), 16'd2);

    // mixed traffic with back-pressure, skew and gaps, compared every cycle
    stall_en = 1;
    for (int r = 0; r < 60; r++) begin
      int len;
      len = 1 + int'($urandom % 8);
      for (int e = 0; e < len; e++)
        push_pair(16'($urandom), 16'($urandom), e == len - 1, int'($urandom % 3));
      if ($urandom % 2 == 1) begin
        drop();
        repeat (int'($urandom % 3)) @(negedge clk);
      end
    end
    drop();
    stall_en = 0;
    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule